// File: doc/BRIEF.md
# Cache Miss Three-Way Classifier

This block observes a stream of memory accesses and labels each one for a set-associative cache of configurable geometry. An access is labelled as a hit, a first-touch (compulsory) miss, a capacity miss or a conflict miss. Only cache tags and replacement state are modelled. No data is stored, no memory traffic is produced and no write policy applies. The block suits performance monitoring beside a real cache, or use as a standalone analysis engine fed from a trace.

Three structures are consulted for every access:
- a tag model of the real set-associative cache;
- a fully associative shadow tag store with the same total number of lines;
- a bit per block recording whether that block has ever been referenced.

A real miss whose block the shadow still holds is a conflict miss: it is caused by set mapping, not by total size. A real miss that also misses the shadow, on a block seen before, is a capacity miss. The label appears one cycle after the access, and four saturating counters accumulate the labels.

Top module: `cache_miss_classifier`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears all of its state. After that edge, `cls_valid` is 0, all four counters are 0, both tag stores are empty and no block is recorded as touched.
- R2: An access presented with `acc_valid` high at a clock edge produces `cls_valid` high with its label in `cls_code` after that same edge. The label encoding is 2'b00 hit, 2'b01 compulsory, 2'b10 capacity and 2'b11 conflict.
- R3: The block number is the byte address shifted right by log2(BLK_BYTES), where BLK_BYTES defaults to 64. The set is the block number modulo SETS. Two addresses inside one 64-byte block refer to the same line.
- R4: An access to a block that has never been accessed since reset is labelled compulsory (2'b01).
- R5: An access whose block is resident in its set of the real cache is labelled hit (2'b00).
- R6: A real-cache miss on a block that the fully associative shadow still holds is labelled conflict (2'b11). In particular, cycling WAYS+1 blocks through one set labels every reuse as conflict, provided the shadow can hold them.
- R7: A real-cache miss on a previously touched block that also misses in the shadow is labelled capacity (2'b10).
- R8: Each set of the real cache uses true LRU replacement. Its recency order is refreshed on every access to that set, hit or miss, and a miss replaces the least recently used way.
- R9: The shadow holds SETS*WAYS lines, uses true LRU replacement and is updated on every access.
- R10: Each classified access increments the counter of its label by exactly one (`cnt_hit`, `cnt_comp`, `cnt_cap`, `cnt_conf`). A counter at its all-ones value holds that value.
- R11: A cycle with `acc_valid` low gives `cls_valid` low at the next edge and leaves all counters and all recorded state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| cls_valid | output | 1 | Label valid (one cycle after the access) |
| cls_code | output | 2 | Label: 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| cnt_hit | output | COUNT_W | Saturating count of hits |
| cnt_comp | output | COUNT_W | Saturating count of compulsory misses |
| cnt_cap | output | COUNT_W | Saturating count of capacity misses |
| cnt_conf | output | COUNT_W | Saturating count of conflict misses |

## Verification
The bench drives several access patterns, each aimed at one distinction:
- Offsets within a single block separate hits from first touches.
- Three blocks aliasing one two-way set are cycled, so every reuse must be labelled conflict; this separates the shadow lookup from the real lookup.
- Twelve blocks spread over all sets are streamed repeatedly. This overflows both stores, so every reuse is labelled capacity rather than conflict.
- A short interleaving inside one set exposes the LRU victim choice.
- Random addresses with idle gaps, followed by a long run of hits on one block, exercise label mixing and counter saturation against a queue-based reference.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [1:0] {
    CLS_HIT  = 2'b00,
    CLS_COMP = 2'b01,
    CLS_CAP  = 2'b10,
    CLS_CONF = 2'b11
  } cls_e;

  // Priority: a real hit wins; otherwise first touch; otherwise the shadow decides.
  function automatic cls_e classify(logic real_hit, logic seen, logic shadow_hit);
    if (real_hit)        return CLS_HIT;
    else if (!seen)      return CLS_COMP;
    else if (shadow_hit) return CLS_CONF;
    else                 return CLS_CAP;
  endfunction

endpackage

// File: rtl/cmc_sa_tags.sv
module cmc_sa_tags #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0]            vld_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q;

  logic [WAYS-1:0] way_hit;
  logic [WAYS-1:0] way_sel;
  logic [AGE_W-1:0] ref_age;

  always_comb begin
    ref_age = OLDEST;
    for (int w = 0; w < WAYS; w++) begin
      way_hit[w] = vld_q[idx][w] && (tag_q[idx][w] == tag);
    end
    hit = |way_hit;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) ref_age = age_q[idx][w];
    end
    for (int w = 0; w < WAYS; w++) begin
      way_sel[w] = hit ? way_hit[w] : (age_q[idx][w] == OLDEST);
    end
  end

  // Ages form a permutation per set; never-filled ways are always the oldest,
  // so replacing the oldest way fills empty ways first.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          vld_q[s][w] <= 1'b0;
          age_q[s][w] <= AGE_W'(w);
        end
      end
    end else if (upd) begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_sel[w]) begin
          age_q[idx][w] <= '0;
          tag_q[idx][w] <= tag;
          vld_q[idx][w] <= 1'b1;
        end else if (age_q[idx][w] < ref_age) begin
          age_q[idx][w] <= age_q[idx][w] + 1'b1;
        end
      end
    end
  end

  p_way_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
  p_victim_single_r8: assert property (@(posedge clk) disable iff (rst)
    upd |-> $countones(way_sel) == 1);

endmodule

// File: rtl/cmc_fa_shadow.sv
module cmc_fa_shadow #(
  parameter int LINES = 8,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [TAG_W-1:0] tag,
  output logic             hit
);
  localparam int AGE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(LINES - 1);

  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic [LINES-1:0]            vld_q;
  logic [LINES-1:0][AGE_W-1:0] age_q;

  logic [LINES-1:0] line_hit;
  logic [LINES-1:0] line_sel;
  logic [AGE_W-1:0] ref_age;

  // All lines compared at once.
  for (genvar e = 0; e < LINES; e++) begin : g_cmp
    assign line_hit[e] = vld_q[e] && (tag_q[e] == tag);
  end

  assign hit = |line_hit;

  always_comb begin
    ref_age = OLDEST;
    for (int e = 0; e < LINES; e++) begin
      if (line_hit[e]) ref_age = age_q[e];
    end
    for (int e = 0; e < LINES; e++) begin
      line_sel[e] = hit ? line_hit[e] : (age_q[e] == OLDEST);
    end
  end

  for (genvar e = 0; e < LINES; e++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[e] <= '0;
        vld_q[e] <= 1'b0;
        age_q[e] <= AGE_W'(e);
      end else if (upd) begin
        if (line_sel[e]) begin
          tag_q[e] <= tag;
          vld_q[e] <= 1'b1;
          age_q[e] <= '0;
        end else if (age_q[e] < ref_age) begin
          age_q[e] <= age_q[e] + 1'b1;
        end
      end
    end
  end

  p_line_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(line_hit));
  p_fill_single_r9: assert property (@(posedge clk) disable iff (rst)
    upd |-> $countones(line_sel) == 1);

endmodule

// File: rtl/cmc_touch_map.sv
module cmc_touch_map #(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [BLK_W-1:0] blk,
  output logic             seen
);
  localparam int BLOCKS = 1 << BLK_W;

  logic [BLOCKS-1:0] seen_q;

  assign seen = seen_q[blk];

  always_ff @(posedge clk) begin
    if (rst)      seen_q <= '0;
    else if (upd) seen_q[blk] <= 1'b1;
  end

  p_seen_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    upd |=> seen_q[$past(blk)]);

endmodule

// File: rtl/cmc_counters.sv
module cmc_counters #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic [1:0]         code,
  output logic [COUNT_W-1:0] cnt_hit,
  output logic [COUNT_W-1:0] cnt_comp,
  output logic [COUNT_W-1:0] cnt_cap,
  output logic [COUNT_W-1:0] cnt_conf
);
  localparam int NCAT = 4;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [NCAT-1:0][COUNT_W-1:0] cnt_q;

  for (genvar k = 0; k < NCAT; k++) begin : g_cnt
    localparam logic [1:0] KCODE = 2'(k);
    logic bump;
    assign bump = inc && (code == KCODE) && (cnt_q[k] != CNT_MAX);

    always_ff @(posedge clk) begin
      if (rst)       cnt_q[k] <= '0;
      else if (bump) cnt_q[k] <= cnt_q[k] + 1'b1;
    end

    p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
      cnt_q[k] == CNT_MAX |=> cnt_q[k] == CNT_MAX);
    p_step_one_r10: assert property (@(posedge clk) disable iff (rst)
      inc && code == KCODE && cnt_q[k] != CNT_MAX |=> cnt_q[k] == $past(cnt_q[k]) + 1'b1);
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt_q[k]));
  end

  assign cnt_hit  = cnt_q[0];
  assign cnt_comp = cnt_q[1];
  assign cnt_cap  = cnt_q[2];
  assign cnt_conf = cnt_q[3];

endmodule

// File: rtl/cache_miss_classifier.sv
module cache_miss_classifier #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 64,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int COUNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [ADDR_W-1:0]  acc_addr,
  output logic               cls_valid,
  output logic [1:0]         cls_code,
  output logic [COUNT_W-1:0] cnt_hit,
  output logic [COUNT_W-1:0] cnt_comp,
  output logic [COUNT_W-1:0] cnt_cap,
  output logic [COUNT_W-1:0] cnt_conf
);
  import cmc_pkg::*;

  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = BLK_W - IDX_W;
  localparam int LINES = SETS * WAYS;

  function automatic logic [BLK_W-1:0] block_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [IDX_W-1:0] set_of(logic [BLK_W-1:0] b);
    return b[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [BLK_W-1:0] b);
    return b[BLK_W-1:IDX_W];
  endfunction

  // Named internal events.
  logic [BLK_W-1:0] acc_blk;
  logic [IDX_W-1:0] acc_set;
  logic [TAG_W-1:0] acc_tag;
  logic             real_hit;
  logic             shadow_hit;
  logic             seen_before;
  cls_e             cls_now;

  assign acc_blk = block_of(acc_addr);
  assign acc_set = set_of(acc_blk);
  assign acc_tag = tag_of(acc_blk);

  cmc_sa_tags #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)
  ) u_real (
    .clk(clk), .rst(rst), .upd(acc_valid),
    .idx(acc_set), .tag(acc_tag), .hit(real_hit)
  );

  cmc_fa_shadow #(
    .LINES(LINES), .TAG_W(BLK_W)
  ) u_shadow (
    .clk(clk), .rst(rst), .upd(acc_valid),
    .tag(acc_blk), .hit(shadow_hit)
  );

  cmc_touch_map #(
    .BLK_W(BLK_W)
  ) u_touch (
    .clk(clk), .rst(rst), .upd(acc_valid),
    .blk(acc_blk), .seen(seen_before)
  );

  assign cls_now = classify(real_hit, seen_before, shadow_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_valid <= 1'b0;
      cls_code  <= CLS_HIT;
    end else begin
      cls_valid <= acc_valid;
      if (acc_valid) cls_code <= cls_now;
    end
  end

  cmc_counters #(
    .COUNT_W(COUNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .inc(acc_valid), .code(cls_now),
    .cnt_hit(cnt_hit), .cnt_comp(cnt_comp),
    .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
  );

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> cls_valid);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !cls_valid);
  p_cold_misses_all_r4: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !seen_before |-> !real_hit && !shadow_hit);
  p_conf_from_shadow_r6: assert property (@(posedge clk) disable iff (rst)
    acc_valid ##1 (cls_code == CLS_CONF) |-> $past(shadow_hit) && !$past(real_hit));
  p_hit_was_seen_r5: assert property (@(posedge clk) disable iff (rst)
    acc_valid && real_hit |-> seen_before);

endmodule

// File: tb/cache_miss_classifier_bench.sv
module cache_miss_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 16;
  localparam int OFF_W   = 6;
  localparam int SETS    = 4;
  localparam int WAYS    = 2;
  localparam int LINES   = SETS * WAYS;
  localparam int COUNT_W = 8;
  localparam int CMAX    = (1 << COUNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic cls_valid;
  logic [1:0] cls_code;
  logic [COUNT_W-1:0] cnt_hit, cnt_comp, cnt_cap, cnt_conf;

  cache_miss_classifier #(
    .ADDR_W(ADDR_W), .BLK_BYTES(64), .SETS(SETS), .WAYS(WAYS), .COUNT_W(COUNT_W)
  ) u_cache_miss_classifier (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .cls_valid(cls_valid), .cls_code(cls_code),
    .cnt_hit(cnt_hit), .cnt_comp(cnt_comp), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference model: MRU-first queues of block numbers.
  int rq [SETS][$];
  int sq [$];
  bit seen [int];
  bit exp_v = 0;
  int exp_code = 0;
  int exp_cnt [4] = '{0, 0, 0, 0};

  function automatic string req_of(int c);
    case (c)
      0: return "R5";
      1: return "R4";
      2: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic fail_line(string rq_tag, string what, int act, int expv);
    n_bad++;
    $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", rq_tag, what, act, expv, $time);
  endtask

  task automatic check_outputs(string ctx);
    n_vec++;
    if (cls_valid !== exp_v)
      fail_line(exp_v ? "R2" : "R11", {ctx, " cls_valid"}, int'(cls_valid), int'(exp_v));
    else if (exp_v && int'(cls_code) != exp_code)
      fail_line(req_of(exp_code), {ctx, " cls_code"}, int'(cls_code), exp_code);
    if (int'(cnt_hit)  != exp_cnt[0]) fail_line("R10", {ctx, " cnt_hit"},  int'(cnt_hit),  exp_cnt[0]);
    if (int'(cnt_comp) != exp_cnt[1]) fail_line("R10", {ctx, " cnt_comp"}, int'(cnt_comp), exp_cnt[1]);
    if (int'(cnt_cap)  != exp_cnt[2]) fail_line("R10", {ctx, " cnt_cap"},  int'(cnt_cap),  exp_cnt[2]);
    if (int'(cnt_conf) != exp_cnt[3]) fail_line("R10", {ctx, " cnt_conf"}, int'(cnt_conf), exp_cnt[3]);
  endtask

  // One clock: check the previous cycle's result, then launch the next input.
  task automatic drive(bit v, int addr);
    int q [$];
    int blk;
    int s;
    bit rh;
    bit sh;
    @(negedge clk);
    check_outputs("step");
    acc_valid = v;
    acc_addr  = ADDR_W'(addr);
    exp_v = v;
    if (v) begin
      blk = (addr & ((1 << ADDR_W) - 1)) >> OFF_W;   // R3 block number
      s = blk % SETS;                                 // R3 set index
      rh = 0;
      sh = 0;
      q = rq[s];
      for (int i = 0; i < q.size(); i++) begin
        if (q[i] == blk) begin rh = 1; q.delete(i); break; end
      end
      q.push_front(blk);
      if (q.size() > WAYS) void'(q.pop_back());      // R8 LRU way dropped
      rq[s] = q;
      for (int i = 0; i < sq.size(); i++) begin
        if (sq[i] == blk) begin sh = 1; sq.delete(i); break; end
      end
      sq.push_front(blk);
      if (sq.size() > LINES) void'(sq.pop_back());   // R9 shadow LRU
      if (rh)                    exp_code = 0;
      else if (!seen.exists(blk)) exp_code = 1;
      else if (sh)               exp_code = 3;
      else                       exp_code = 2;
      seen[blk] = 1'b1;
      if (exp_cnt[exp_code] < CMAX) exp_cnt[exp_code]++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    @(negedge clk);
    n_vec++;
    if (cls_valid !== 1'b0) fail_line("R1", "cls_valid after reset", int'(cls_valid), 0);
    n_vec++;
    if ((cnt_hit | cnt_comp | cnt_cap | cnt_conf) != '0)
      fail_line("R1", "counters after reset", int'(cnt_hit | cnt_comp | cnt_cap | cnt_conf), 0);

    // R3, R4, R5: offsets inside a block, a second block in the next set
    drive(1, 'h0000);
    drive(1, 'h003F);
    drive(1, 'h0040);
    drive(1, 'h0020);

    // R6: three blocks aliasing set 0 of a two-way cache
    for (int r = 0; r < 4; r++) begin
      drive(1, 'h0000);
      drive(1, 'h0100);
      drive(1, 'h0200);
    end

    // R11: idle cycles leave labels off and counters unchanged
    for (int i = 0; i < 4; i++) drive(0, 'h0000);
    drive(1, 'h0200);

    // R8: LRU victim choice in set 2
    drive(1, 'h0080);  // block 2
    drive(1, 'h0180);  // block 6
    drive(1, 'h0080);  // block 2 hit, block 6 now LRU
    drive(1, 'h0280);  // block 10 evicts block 6
    drive(1, 'h0080);  // block 2 still resident
    drive(1, 'h0180);  // block 6 misses, shadow holds it

    // R7, R9: twelve blocks across all sets overflow both stores
    for (int r = 0; r < 3; r++) begin
      for (int b = 16; b < 28; b++) drive(1, b << OFF_W);
    end

    // Mixed random traffic with idle gaps
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(4) == 0) drive(0, 0);
      else drive(1, ($urandom_range(39) << OFF_W) | $urandom_range(63));
    end

    // R10: long run of hits drives the hit counter to saturation
    for (int i = 0; i < 300; i++) drive(1, 'h0440);

    drive(0, 0);
    drive(0, 0);
    check_outputs("final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule